// File: doc/BRIEF.md
# Spare-Partition Diagnosis and Reconfiguration Controller

This controller locates a faulty partition by trial and error once an error has been detected and the datapath has been brought back to a known-good checkpoint. The datapath is split into `NPART` partitions. Each partition has a primary copy and one spare. One select bit per partition chooses which copy is live: 0 selects the primary and 1 selects the spare. When `diag_start` arrives, the controller works through the partitions from index 0 upward. For each one it builds a trial configuration that flips that partition's select bit. It pulses `restore_req` so the replay engine rolls back to the checkpoint, and it holds the trial on `cfg_sel` while the replay runs.

When a replay finishes cleanly, the trial becomes the committed configuration and the copy that was taken out of service is recorded as defective. When the replay reports an error, the controller moves on to the next partition. A partition whose alternate copy is already recorded as bad is passed over without a replay. If no swap clears the error after every partition has been considered, the controller raises a sticky fatal flag and goes back to driving the last committed configuration.

Internally the controller keeps four vectors, all `NPART` wide:
- the committed configuration;
- a one-hot pointer to the partition under trial;
- a record of bad alternates;
- the trial configuration itself.

The replay engine and the partitions themselves sit outside this block.

Top module: `diag_reconfig_ctrl`

States:
- `ST_IDLE` waits for a start request.
- `ST_PICK` chooses the next trial, or skips it, or detects that the trials are exhausted.
- `ST_RESTORE` issues the one-cycle restore.
- `ST_REPLAY` waits for the replay result.
- `ST_FATAL` is terminal until reset.

Transitions:
- IDLE to PICK on start.
- PICK to PICK on a skip.
- PICK to RESTORE when the pointed partition is usable.
- PICK to FATAL when exhausted.
- RESTORE to REPLAY always.
- REPLAY to PICK on an erroneous replay.
- REPLAY to IDLE on a clean replay, which is the commit.

## Requirements
- R1: After reset `cfg_sel` is all zeros (every primary live), and `busy`, `fatal` and `restore_req` are low.
- R2: `diag_start` while idle raises `busy` from the next cycle until a commit or the fatal outcome. `diag_start` while busy has no effect on the search in progress.
- R3: Partitions are tried in ascending index order, starting at 0. Each trial configuration equals the committed configuration with exactly the tried partition's bit inverted.
- R4: Each trial starts with `restore_req` high for exactly one cycle, with `cfg_sel` already showing the trial. `cfg_sel` then holds the trial unchanged until `replay_done`.
- R5: `replay_done` with `replay_err` high abandons the current trial, and the next partition's trial follows.
- R6: `replay_done` with `replay_err` low commits the trial. `cfg_sel` keeps that value, `busy` falls the next cycle, and the tried partition's alternate copy is recorded as defective.
- R7: A partition whose alternate copy is recorded as defective is skipped, with no `restore_req` issued for it.
- R8: Once all `NPART` partitions have been considered without a clean replay, `fatal` rises, `busy` falls and `cfg_sel` returns to the committed configuration. `fatal` stays high until reset, and `diag_start` is then ignored.
- R9: `replay_done` outside a replay is ignored. While idle, `cfg_sel` does not change.
- R10: When every partition's alternate is recorded as defective, a start request leads to `fatal` with no `restore_req` at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| diag_start | input | 1 | Begin a diagnosis search |
| replay_done | input | 1 | Replay finished this cycle |
| replay_err | input | 1 | The finished replay saw an error (valid with replay_done) |
| restore_req | output | 1 | One-cycle request to roll back to the checkpoint |
| cfg_sel | output | NPART | Spare-select per partition (1 = spare live) |
| busy | output | 1 | Search in progress |
| fatal | output | 1 | No swap cleared the error; sticky |

## Verification
The bench keeps its own model of the committed configuration and of the recorded bad alternates. Against that model it checks the trial shown at every restore, so a design that flipped the wrong bit, or that kept an earlier trial's flip, reports a mismatched `cfg_sel`.

Several directed sequences target specific faults:
- Successive commits fill the defect record until nothing is usable. A controller that failed to skip bad alternates would issue an unexpected restore, or reach fatal too late.
- An all-fail search checks that fatal restores the committed configuration and stays sticky. It catches a design that leaks a trial value or that restarts on a later start request.
- Stray `replay_done` pulses while idle, and extra start pulses mid-replay, expose a design that commits or restarts on the wrong state.

// File: rtl/dgn_pkg.sv
package dgn_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_RESTORE,
        ST_REPLAY,
        ST_FATAL
    } dgn_state_e;
endpackage

// File: rtl/dgn_trial_gen.sv
module dgn_trial_gen #(
    parameter int NPART = 4
) (
    input  logic [NPART-1:0] cfg,
    input  logic [NPART-1:0] ptr,
    input  logic [NPART-1:0] defects,
    output logic [NPART-1:0] trial,
    output logic             usable
);
    logic [NPART-1:0] flip;

    // The flip is masked where the alternate copy is known bad. A masked
    // flip leaves the trial equal to the configuration, which means skip.
    always_comb begin
        flip   = ptr & ~defects;
        trial  = cfg ^ flip;
        usable = (trial != cfg);
    end
endmodule

// File: rtl/dgn_vec_regs.sv
module dgn_vec_regs #(
    parameter int NPART = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             advance,
    input  logic             load,
    input  logic             commit,
    input  logic [NPART-1:0] trial_in,
    output logic [NPART-1:0] cfg_q,
    output logic [NPART-1:0] trial_q,
    output logic [NPART-1:0] ptr_q,
    output logic [NPART-1:0] defects_q,
    output logic             exhausted
);
    localparam int CW = $clog2(NPART + 1);
    localparam logic [CW-1:0] TRIES_MAX = CW'(NPART);

    logic [CW-1:0] tries_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            tries_q <= '0;
        end else if (init) begin
            ptr_q   <= NPART'(1);
            tries_q <= '0;
        end else if (advance) begin
            ptr_q   <= ptr_q << 1;
            tries_q <= tries_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial_q <= '0;
        end else if (load) begin
            trial_q <= trial_in;
        end
    end

    // A commit retires the copy that was just swapped out. The defect bit
    // refers to whichever copy is currently inactive.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            defects_q <= '0;
        end else if (commit) begin
            cfg_q     <= trial_q;
            defects_q <= defects_q | ptr_q;
        end
    end

    assign exhausted = (tries_q == TRIES_MAX);
endmodule

// File: rtl/dgn_fsm.sv
module dgn_fsm
    import dgn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       diag_start,
    input  logic       replay_done,
    input  logic       replay_err,
    input  logic       usable,
    input  logic       exhausted,
    output dgn_state_e state,
    output logic       init,
    output logic       advance,
    output logic       load,
    output logic       commit
);
    dgn_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        init     = 1'b0;
        advance  = 1'b0;
        load     = 1'b0;
        commit   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (diag_start) begin
                    init     = 1'b1;
                    state_nx = ST_PICK;
                end
            end
            ST_PICK: begin
                if (exhausted) begin
                    state_nx = ST_FATAL;
                end else if (!usable) begin
                    advance = 1'b1;
                end else begin
                    load     = 1'b1;
                    state_nx = ST_RESTORE;
                end
            end
            ST_RESTORE: state_nx = ST_REPLAY;
            ST_REPLAY: begin
                if (replay_done) begin
                    if (replay_err) begin
                        advance  = 1'b1;
                        state_nx = ST_PICK;
                    end else begin
                        commit   = 1'b1;
                        state_nx = ST_IDLE;
                    end
                end
            end
            ST_FATAL: state_nx = ST_FATAL;
            default:  state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/diag_reconfig_ctrl.sv
module diag_reconfig_ctrl
    import dgn_pkg::*;
#(
    parameter int NPART = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             diag_start,
    input  logic             replay_done,
    input  logic             replay_err,
    output logic             restore_req,
    output logic [NPART-1:0] cfg_sel,
    output logic             busy,
    output logic             fatal
);
    dgn_state_e       state;
    logic             init, advance, load, commit;
    logic             usable, exhausted;
    logic [NPART-1:0] cfg_q, trial_q, ptr_q, defects_q, trial_c;
    logic             in_replay;

    dgn_trial_gen #(.NPART(NPART)) u_trial (
        .cfg     (cfg_q),
        .ptr     (ptr_q),
        .defects (defects_q),
        .trial   (trial_c),
        .usable  (usable)
    );

    dgn_vec_regs #(.NPART(NPART)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (init),
        .advance   (advance),
        .load      (load),
        .commit    (commit),
        .trial_in  (trial_c),
        .cfg_q     (cfg_q),
        .trial_q   (trial_q),
        .ptr_q     (ptr_q),
        .defects_q (defects_q),
        .exhausted (exhausted)
    );

    dgn_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .diag_start  (diag_start),
        .replay_done (replay_done),
        .replay_err  (replay_err),
        .usable      (usable),
        .exhausted   (exhausted),
        .state       (state),
        .init        (init),
        .advance     (advance),
        .load        (load),
        .commit      (commit)
    );

    always_comb begin
        in_replay   = (state == ST_REPLAY);
        restore_req = (state == ST_RESTORE);
        busy        = (state != ST_IDLE) && (state != ST_FATAL);
        fatal       = (state == ST_FATAL);
        cfg_sel     = (restore_req || in_replay) ? trial_q : cfg_q;
    end
endmodule

// File: rtl/dgn_checker.sv
module dgn_checker #(
    parameter int NPART = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             diag_start,
    input logic             replay_done,
    input logic             replay_err,
    input logic             restore_req,
    input logic [NPART-1:0] cfg_sel,
    input logic [NPART-1:0] cfg_commit,
    input logic             in_replay,
    input logic             busy,
    input logic             fatal
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!busy && !fatal && !restore_req));

    assert_restore_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |=> !restore_req);

    assert_trial_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_replay && !replay_done) |=> $stable(cfg_sel));

    assert_single_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |-> ($countones(cfg_sel ^ cfg_commit) == 1));

    assert_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_replay && replay_done && !replay_err) |=> (!busy && cfg_commit == $past(cfg_sel)));

    assert_fatal_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> (fatal && !busy && cfg_sel == cfg_commit));

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !fatal && !diag_start) |=> $stable(cfg_sel));

    assert_busy_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && fatal));
endmodule

bind diag_reconfig_ctrl dgn_checker #(.NPART(NPART)) u_dgn_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .diag_start  (diag_start),
    .replay_done (replay_done),
    .replay_err  (replay_err),
    .restore_req (restore_req),
    .cfg_sel     (cfg_sel),
    .cfg_commit  (cfg_q),
    .in_replay   (in_replay),
    .busy        (busy),
    .fatal       (fatal)
);

// File: tb/test_diag_reconfig_ctrl.sv
module test_diag_reconfig_ctrl;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         diag_start = 1'b0;
    logic         replay_done = 1'b0;
    logic         replay_err = 1'b0;
    logic         restore_req;
    logic [N-1:0] cfg_sel;
    logic         busy;
    logic         fatal;

    int errors = 0;
    int checks = 0;
    logic [N-1:0] cfg_m;
    logic [N-1:0] def_m;
    bit           is_fatal;

    always #4 clk = ~clk;

    diag_reconfig_ctrl #(.NPART(N)) i_diag_reconfig_ctrl (
        .clk, .rst_n, .diag_start, .replay_done, .replay_err,
        .restore_req, .cfg_sel, .busy, .fatal
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] flip_bit(input logic [N-1:0] c, input int i);
        return c ^ (N'(1) << i);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        diag_start = 0; replay_done = 0; replay_err = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cfg_m = '0; def_m = '0; is_fatal = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); diag_start = 1'b1;
        @(negedge clk); diag_start = 1'b0;
    endtask

    task automatic pulse_done(input bit err);
        @(negedge clk); replay_done = 1'b1; replay_err = err;
        @(negedge clk); replay_done = 1'b0; replay_err = 1'b0;
    endtask

    // Poll for a restore or fatal; returns 1 on restore.
    task automatic wait_event(output bit got_restore);
        got_restore = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (restore_req) begin got_restore = 1; return; end
            if (fatal) return;
        end
    endtask

    // One diagnosis; partition succ is the one whose swap replays cleanly (N = none).
    task automatic run_diag(input int succ, input bit poke_start);
        bit got;
        pulse_start();
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        for (int i = 0; i < N; i++) begin
            if (def_m[i]) continue;  // R7 expected skip
            wait_event(got);
            chk(got, "R7/R3 restore expected for partition", int'(fatal), 0);
            if (!got) return;
            chk(cfg_sel == flip_bit(cfg_m, i), "R3 trial config", cfg_sel, flip_bit(cfg_m, i));
            @(negedge clk);
            chk(restore_req == 1'b0, "R4 restore single cycle", restore_req, 0);
            chk(cfg_sel == flip_bit(cfg_m, i), "R4 trial held", cfg_sel, flip_bit(cfg_m, i));
            if (poke_start) begin
                pulse_start();
                chk(restore_req == 1'b0 && cfg_sel == flip_bit(cfg_m, i),
                    "R2 start ignored while busy", cfg_sel, flip_bit(cfg_m, i));
            end
            if (i == succ) begin
                pulse_done(1'b0);
                cfg_m = flip_bit(cfg_m, i);
                def_m[i] = 1'b1;
                @(negedge clk);
                chk(busy == 1'b0, "R6 busy low after commit", busy, 0);
                chk(cfg_sel == cfg_m, "R6 committed config", cfg_sel, cfg_m);
                chk(fatal == 1'b0, "R6 no fatal", fatal, 0);
                return;
            end
            pulse_done(1'b1);  // R5 move on
        end
        wait_event(got);
        chk(!got, "R7 no restore after last usable trial", int'(got), 0);
        chk(fatal == 1'b1, "R8 fatal after exhaustion", fatal, 1);
        chk(busy == 1'b0, "R8 busy low at fatal", busy, 0);
        chk(cfg_sel == cfg_m, "R8 committed config restored", cfg_sel, cfg_m);
        is_fatal = 1;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit got;
        void'($urandom(32'd2718));
        do_reset();
        @(negedge clk);
        chk(cfg_sel == '0, "R1 reset cfg", cfg_sel, 0);
        chk(!busy && !fatal && !restore_req, "R1 reset flags",
            {busy, fatal, restore_req}, 0);

        // R9: stray replay_done while idle
        pulse_done(1'b0);
        pulse_done(1'b1);
        @(negedge clk);
        chk(cfg_sel == '0 && !busy, "R9 idle replay_done ignored", cfg_sel, 0);

        // Directed: first trial succeeds, then an all-fail search
        run_diag(0, 1'b0);
        run_diag(N, 1'b1);
        pulse_start();
        repeat (2) @(negedge clk);
        chk(fatal && !busy && cfg_sel == cfg_m, "R8 fatal sticky, start ignored",
            {fatal, busy}, 2'b10);

        // Directed: commit each partition in turn, then nothing is usable
        do_reset();
        for (int p = 0; p < N; p++) run_diag(p, 1'b0);
        pulse_start();
        wait_event(got);
        chk(!got && fatal, "R10 no usable alternate -> fatal", {got, fatal}, 2'b01);
        chk(cfg_sel == cfg_m, "R10 config kept", cfg_sel, cfg_m);

        // Random searches
        do_reset();
        for (int t = 0; t < 40; t++) begin
            run_diag(int'($urandom_range(0, N)), bit'($urandom_range(0, 1)));
            if (is_fatal) do_reset();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule